// File: doc/BRIEF.md
# Eight-Level Nested Interrupt Prioritizer

This block collects eight interrupt request lines into a request register and picks, under a fixed priority with line 0 highest and line 7 lowest, the best request that no mask bit blocks. It raises an interrupt to the processor only when that request outranks every level already being serviced. Service can therefore nest: a more urgent line can interrupt a handler of a less urgent one, but never the other way round.

The processor answers with a one-cycle acknowledge strobe. On that strobe the winning level moves from the request register into the in-service register, and its 3-bit number is returned one cycle later together with a valid pulse. When a handler finishes, an end-of-service strobe retires the most urgent level in service, and the interrupt output is evaluated again. A small register port writes the mask and reads back the request, in-service and mask registers.

Top module: `nip_top`

## Requirements
- R1: While `rst` is high at a clock edge, the request, in-service and mask registers become 0, and `int_req` and `ack_valid` become 0.
- R2: A line high before a clock edge sets its request bit at that edge, and the bit stays set after the line falls until that level is acknowledged.
- R3: `cfg_wr` loads `cfg_wdata` into the mask register at the clock edge; a level whose mask bit is 1 never wins resolution, never raises `int_req` and is never acknowledged.
- R4: Masking a level does not stop unmasked levels of lower priority from being resolved, signalled and acknowledged.
- R5: Priority is fixed: among unmasked pending requests the lowest-numbered line wins.
- R6: `int_req` is registered: it is 1 in the cycle after an edge at which an unmasked request was pending whose level number is lower than the lowest-numbered set in-service bit (or the in-service register was empty) and no acknowledge was present; otherwise it is 0.
- R7: When `ack_strobe` is high at an edge and a qualifying request exists (as in R6), the winner's in-service bit is set and its request bit cleared at that edge, `ack_valid` is 1 for the next cycle and `ack_code` holds the winner's level number as an unsigned 3-bit value; a line still held high sets its request bit again at the following edge.
- R8: `int_req` is 0 in the cycle after any edge at which `ack_strobe` was high.
- R9: `eoi_strobe` at an edge clears only the lowest-numbered set in-service bit; if an acknowledge happens at the same edge, its new bit is set and is not the one cleared.
- R10: `rd_data` shows the request register when `rd_sel` is 0, the in-service register when 1, the mask register when 2, and zero when 3; bit n is level n.
- R11: An acknowledge strobe with no qualifying request changes no register and leaves `ack_valid` at 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_lines | input | 8 | Interrupt request lines, bit n is level n |
| int_req | output | 1 | Interrupt to the processor |
| ack_strobe | input | 1 | One-cycle acknowledge from the processor |
| ack_valid | output | 1 | Pulse marking a granted acknowledge |
| ack_code | output | 3 | Level number granted by the last acknowledge |
| eoi_strobe | input | 1 | End-of-service strobe |
| cfg_wr | input | 1 | Mask write enable |
| cfg_wdata | input | 8 | Mask value to write |
| rd_sel | input | 2 | Readback register select |
| rd_data | output | 8 | Readback data |

## Verification
The bench sweeps every one of the 256 mask values with all eight lines pending, so a resolver that let a masked line win, or that stopped at the first masked line instead of skipping it, gives a wrong code. Nested service is checked directly: a request below the level in service must stay silent while a more urgent one must interrupt, which a design comparing against the wrong in-service bit or ignoring the in-service register fails. An end-of-service strobe with several levels in service must clear exactly the most urgent one, and a strobe arriving with the same-cycle acknowledge must not remove the newly granted bit. A long pseudo-random run of lines, acknowledges, ends of service and mask writes compares every register and output each cycle against an arithmetic model.

// File: rtl/nip_pkg.sv
package nip_pkg;

    localparam int LVL_N  = 8;
    localparam int CODE_W = $clog2(LVL_N);

    typedef logic [LVL_N-1:0]  lvl_vec_t;
    typedef logic [CODE_W-1:0] lvl_code_t;

    // Result of a priority search over a level vector
    typedef struct packed {
        logic      hit;
        lvl_code_t code;
    } pick_t;

    typedef enum logic [1:0] {
        SEL_REQ  = 2'd0,
        SEL_SVC  = 2'd1,
        SEL_MASK = 2'd2,
        SEL_NONE = 2'd3
    } rd_sel_e;

    // Lowest-numbered set bit wins (level 0 is most urgent)
    function automatic pick_t pick_first(lvl_vec_t v);
        pick_t p;
        p.hit  = 1'b0;
        p.code = '0;
        for (int i = LVL_N - 1; i >= 0; i--) begin
            if (v[i]) begin
                p.hit  = 1'b1;
                p.code = lvl_code_t'(i);
            end
        end
        return p;
    endfunction

    function automatic lvl_vec_t code_to_vec(lvl_code_t c);
        return lvl_vec_t'(1) << c;
    endfunction

endpackage

// File: rtl/nip_req_reg.sv
module nip_req_reg
    import nip_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t lines,
    input  lvl_vec_t clr_vec,
    output lvl_vec_t req_q
);

    // One sticky bit per level: set by its line, cleared by a grant
    for (genvar g = 0; g < LVL_N; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                req_q[g] <= 1'b0;
            end else begin
                req_q[g] <= (req_q[g] | lines[g]) & ~clr_vec[g];
            end
        end
    end

endmodule

// File: rtl/nip_svc_reg.sv
module nip_svc_reg
    import nip_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  lvl_vec_t set_vec,
    input  logic     eoi,
    output lvl_vec_t svc_q,
    output pick_t    svc_top
);

    lvl_vec_t eoi_clr;

    always_comb begin
        svc_top = pick_first(svc_q);
        eoi_clr = '0;
        if (eoi && svc_top.hit) begin
            eoi_clr = code_to_vec(svc_top.code);
        end
    end

    // Retire the most urgent level, then add any newly granted one
    always_ff @(posedge clk) begin
        if (rst) begin
            svc_q <= '0;
        end else begin
            svc_q <= (svc_q & ~eoi_clr) | set_vec;
        end
    end

endmodule

// File: rtl/nip_resolver.sv
module nip_resolver
    import nip_pkg::*;
(
    input  lvl_vec_t req_q,
    input  lvl_vec_t mask_q,
    input  pick_t    svc_top,
    output pick_t    win,
    output logic     qualify
);

    always_comb begin
        win     = pick_first(req_q & ~mask_q);
        qualify = win.hit && (!svc_top.hit || (win.code < svc_top.code));
    end

endmodule

// File: rtl/nip_top.sv
module nip_top
    import nip_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [LVL_N-1:0]  irq_lines,
    output logic              int_req,
    input  logic              ack_strobe,
    output logic              ack_valid,
    output logic [CODE_W-1:0] ack_code,
    input  logic              eoi_strobe,
    input  logic              cfg_wr,
    input  logic [LVL_N-1:0]  cfg_wdata,
    input  logic [1:0]        rd_sel,
    output logic [LVL_N-1:0]  rd_data
);

    lvl_vec_t  irr_q;
    lvl_vec_t  isr_q;
    lvl_vec_t  mask_q;
    lvl_vec_t  grant_vec;
    pick_t     svc_top;
    pick_t     win;
    logic      qualify;
    logic      take;
    logic      int_q;
    logic      ack_v_q;
    lvl_code_t ack_c_q;

    nip_req_reg u_req (
        .clk     (clk),
        .rst     (rst),
        .lines   (irq_lines),
        .clr_vec (grant_vec),
        .req_q   (irr_q)
    );

    nip_svc_reg u_svc (
        .clk     (clk),
        .rst     (rst),
        .set_vec (grant_vec),
        .eoi     (eoi_strobe),
        .svc_q   (isr_q),
        .svc_top (svc_top)
    );

    nip_resolver u_res (
        .req_q   (irr_q),
        .mask_q  (mask_q),
        .svc_top (svc_top),
        .win     (win),
        .qualify (qualify)
    );

    always_comb begin
        take      = ack_strobe && qualify;
        grant_vec = take ? code_to_vec(win.code) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q  <= '0;
            int_q   <= 1'b0;
            ack_v_q <= 1'b0;
            ack_c_q <= '0;
        end else begin
            if (cfg_wr) begin
                mask_q <= cfg_wdata;
            end
            int_q   <= ack_strobe ? 1'b0 : qualify;
            ack_v_q <= take;
            if (take) begin
                ack_c_q <= win.code;
            end
        end
    end

    always_comb begin
        unique case (rd_sel_e'(rd_sel))
            SEL_REQ:  rd_data = irr_q;
            SEL_SVC:  rd_data = isr_q;
            SEL_MASK: rd_data = mask_q;
            default:  rd_data = '0;
        endcase
    end

    assign int_req   = int_q;
    assign ack_valid = ack_v_q;
    assign ack_code  = ack_c_q;

endmodule

// File: rtl/nip_chk.sv
module nip_chk
    import nip_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      int_req,
    input logic      ack_strobe,
    input logic      ack_valid,
    input lvl_code_t ack_code,
    input logic      eoi_strobe,
    input lvl_vec_t  irr_q,
    input lvl_vec_t  isr_q,
    input lvl_vec_t  mask_q
);

    p_int_low_after_ack_r8: assert property (@(posedge clk) disable iff (rst)
        ack_strobe |=> !int_req);

    p_valid_follows_ack_r7: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> $past(ack_strobe));

    p_granted_in_service_r7: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> ((isr_q & (lvl_vec_t'(1) << ack_code)) != '0));

    p_masked_never_granted_r3: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (($past(mask_q) & (lvl_vec_t'(1) << ack_code)) == '0));

    p_int_needs_pending_r6: assert property (@(posedge clk) disable iff (rst)
        int_req |-> (($past(irr_q) & ~$past(mask_q)) != '0));

    p_eoi_single_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (eoi_strobe && !ack_strobe) |=>
            ($countones($past(isr_q) & ~isr_q) <= 1) && ((isr_q & ~$past(isr_q)) == '0));

    p_idle_ack_no_change_r11: assert property (@(posedge clk) disable iff (rst)
        (!ack_strobe && !eoi_strobe) |=> $stable(isr_q));

endmodule

bind nip_top nip_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .int_req    (int_req),
    .ack_strobe (ack_strobe),
    .ack_valid  (ack_valid),
    .ack_code   (ack_code),
    .eoi_strobe (eoi_strobe),
    .irr_q      (irr_q),
    .isr_q      (isr_q),
    .mask_q     (mask_q)
);

// File: tb/nip_top_tb.sv
`timescale 1ns/100ps
module nip_top_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] irq_lines = '0;
    logic       int_req;
    logic       ack_strobe = 1'b0;
    logic       ack_valid;
    logic [2:0] ack_code;
    logic       eoi_strobe = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // reference state
    logic [7:0] m_irr, m_isr, m_mask;
    logic       m_int, m_av;
    logic [2:0] m_ac;

    always #2 clk = ~clk;

    nip_top u_dut (
        .clk        (clk),
        .rst        (rst),
        .irq_lines  (irq_lines),
        .int_req    (int_req),
        .ack_strobe (ack_strobe),
        .ack_valid  (ack_valid),
        .ack_code   (ack_code),
        .eoi_strobe (eoi_strobe),
        .cfg_wr     (cfg_wr),
        .cfg_wdata  (cfg_wdata),
        .rd_sel     (rd_sel),
        .rd_data    (rd_data)
    );

    function automatic int low_idx(logic [7:0] v);
        for (int i = 0; i < 8; i++) if (v[i]) return i;
        return 8;
    endfunction

    task automatic chk(input int act, input int exp, input string tag);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic rd(input int sel, output logic [7:0] v);
        rd_sel = sel[1:0];
        #0.1;
        v = rd_data;
    endtask

    task automatic step(input logic [7:0] ln, input logic ak, input logic ek,
                        input logic wr, input logic [7:0] wd);
        int w, t;
        logic q;
        logic [7:0] clr;
        @(negedge clk);
        irq_lines = ln; ack_strobe = ak; eoi_strobe = ek; cfg_wr = wr; cfg_wdata = wd;
        @(posedge clk);
        w = low_idx(m_irr & ~m_mask);
        t = low_idx(m_isr);
        q = (w < 8) && (w < t);
        clr = '0;
        m_av = 1'b0;
        if (ak && q) begin
            clr  = 8'd1 << w;
            m_av = 1'b1;
            m_ac = w[2:0];
        end
        if (ek && t < 8) m_isr = m_isr & ~(8'd1 << t);
        m_isr = m_isr | clr;
        m_irr = (m_irr | ln) & ~clr;
        m_int = ak ? 1'b0 : q;
        if (wr) m_mask = wd;
        #0.4;
        chk(int_req, m_int, "R6");
        chk(ack_valid, m_av, "R7");
        if (m_av) chk(ack_code, m_ac, "R7");
        for (int s = 0; s < 4; s++) begin
            rd_sel = s[1:0];
            #0.25;
            case (s)
                0: chk(rd_data, m_irr, "R2");
                1: chk(rd_data, m_isr, "R9");
                2: chk(rd_data, m_mask, "R3");
                default: chk(rd_data, 0, "R10");
            endcase
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [15:0] lf;
        m_irr = '0; m_isr = '0; m_mask = '0; m_int = 0; m_av = 0; m_ac = '0;

        // R1: reset with lines active still leaves everything clear
        irq_lines = 8'hFF;
        repeat (3) @(posedge clk);
        #0.5;
        chk(int_req, 0, "R1");
        chk(ack_valid, 0, "R1");
        rd(0, v); chk(v, 0, "R1");
        rd(1, v); chk(v, 0, "R1");
        rd(2, v); chk(v, 0, "R1");
        @(negedge clk);
        rst = 1'b0;
        irq_lines = '0;

        // R11: acknowledge with nothing pending
        step(8'h00, 1, 0, 0, 0);
        chk(ack_valid, 0, "R11");
        rd(1, v); chk(v, 0, "R11");

        // R5/R7/R8: each level alone, one-cycle pulse latched (R2)
        for (int i = 0; i < 8; i++) begin
            step(8'd1 << i, 0, 0, 0, 0);
            step(8'h00, 0, 0, 0, 0);
            chk(int_req, 1, "R6");
            step(8'h00, 1, 0, 0, 0);
            chk(ack_valid, 1, "R7");
            chk(ack_code, i, "R5");
            chk(int_req, 0, "R8");
            rd(1, v); chk(v, 8'd1 << i, "R7");
            step(8'h00, 0, 1, 0, 0);
            rd(1, v); chk(v, 0, "R9");
        end

        // R6 nesting: level 5 in service; 6 blocked, 2 interrupts
        step(8'h20, 0, 0, 0, 0);
        step(8'h00, 1, 0, 0, 0);
        chk(ack_code, 5, "R7");
        step(8'h40, 0, 0, 0, 0);
        step(8'h00, 0, 0, 0, 0);
        step(8'h00, 0, 0, 0, 0);
        chk(int_req, 0, "R6");
        step(8'h04, 0, 0, 0, 0);
        step(8'h00, 0, 0, 0, 0);
        chk(int_req, 1, "R6");
        step(8'h00, 1, 0, 0, 0);
        chk(ack_code, 2, "R5");
        rd(1, v); chk(v, 8'h24, "R7");
        step(8'h00, 0, 1, 0, 0);
        rd(1, v); chk(v, 8'h20, "R9");
        step(8'h00, 0, 0, 0, 0);
        chk(int_req, 0, "R6");
        // R9: end of service with same-cycle grant keeps the new bit
        step(8'h08, 0, 0, 0, 0);
        step(8'h00, 0, 0, 0, 0);
        step(8'h00, 1, 1, 0, 0);
        rd(1, v); chk(v, 8'h08, "R9");
        step(8'h00, 0, 1, 0, 0);
        step(8'h00, 0, 0, 0, 0);
        chk(int_req, 1, "R6");
        step(8'h00, 1, 0, 0, 0);
        chk(ack_code, 6, "R5");
        step(8'h00, 0, 1, 0, 0);

        // R7: held line sets its request again after the grant
        step(8'h08, 0, 0, 0, 0);
        step(8'h08, 1, 0, 0, 0);
        rd(0, v); chk(v, 8'h00, "R7");
        step(8'h08, 0, 0, 0, 0);
        rd(0, v); chk(v, 8'h08, "R7");
        step(8'h00, 0, 1, 0, 0);
        step(8'h00, 1, 0, 0, 0);
        step(8'h00, 0, 1, 0, 0);

        // R3/R4: every mask with all lines pending
        for (int m = 0; m < 256; m++) begin
            step(8'hFF, 0, 0, 1, m[7:0]);
            step(8'hFF, 0, 0, 0, 0);
            step(8'hFF, 1, 0, 0, 0);
            if (m == 255) begin
                chk(ack_valid, 0, "R3");
            end else begin
                chk(ack_valid, 1, "R4");
                chk(ack_code, low_idx(~m[7:0]), "R4");
            end
            step(8'hFF, 0, 1, 0, 0);
        end
        step(8'h00, 0, 0, 1, 8'h00);

        // mixed pseudo-random traffic
        lf = 16'hACE1;
        for (int k = 0; k < 3000; k++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            step(lf[7:0] & lf[15:8] & {lf[3:0], lf[7:4]},
                 lf[2] & lf[9], lf[5] & lf[11] & lf[0],
                 (lf[15:12] == 4'hA), lf[11:4]);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule